// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped master for the two-wire Ethernet PHY management bus. Software programs a mode word (frame type, clock divider, one stored clock-mode control bit), a target word (PHY address and register or device number), a 16-bit outgoing data word, and then writes a command word. The command word carries a start bit and a two-bit access code. The block derives the management clock from its own clock through an 8-bit divider. It shifts a complete 64-bit frame out on the data line with an output enable, releases the line for the turnaround and data phase of reads, and captures the returned 16 bits into a read-back register.

A busy flag in the command word tells software when a frame is on the wire. In the extended (Clause 45) framing, a full access takes two commands: an address frame that carries the 16-bit register address, then a write or read frame. In the basic (Clause 22) framing, one command performs the whole read or write.

Top module: `mdio_master`

## Requirements
- R1: After reset the mode word (offset 0x40) reads 0x000000FF, the target word (0x44), command word (0x50) and read-back word (0x4C) read 0, and MDC and the output enable are low.
- R2: Mode word fields: bits 7:0 divider N, bit 8 frame type (0 basic, 1 extended), bit 12 a clock-mode control bit that is stored and read back unchanged. The target word holds the PHY address in bits 12:8 and the register or device number in bits 4:0. The outgoing data word at 0x48 uses bits 15:0.
- R3: While a frame runs, MDC has a period of N+1 input clock cycles; a divider value of 0 is treated as 1. MDC stays low while idle.
- R4: Writing 0x50 with bit 8 set and a valid code in bits 1:0 starts a frame; bit 16 of 0x50 reads 1 until the frame ends, and each frame lasts exactly 64 MDC periods.
- R5: Each frame is sent MSB first as 32 ones, a 2-bit start field (01 basic, 00 extended), a 2-bit opcode, the 5-bit PHY address, the 5-bit register/device number, a 2-bit turnaround (10 when the master drives it) and 16 data bits.
- R6: In basic framing, code 1 is a write with opcode 01 carrying the outgoing data word, and code 0 is a read with opcode 10.
- R7: In extended framing, code 0 is an address frame (opcode 00) and code 1 a write frame (opcode 01), both carrying the outgoing data word; code 2 is a read frame (opcode 11).
- R8: In read frames the output enable is low from the first turnaround bit through the last data bit; the input is sampled on each rising MDC edge of the data phase, and the 16-bit result appears in bits 15:0 of 0x4C when the frame ends.
- R9: The data output changes only in the cycle in which MDC falls, or when a frame is loaded.
- R10: A start request written while a frame is running is ignored: the running frame completes unchanged, no further frame follows, and the stored code in 0x50 bits 1:0 keeps its value.
- R11: Codes 2 and 3 in basic framing and code 3 in extended framing start nothing: busy stays 0 and MDC does not toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, also the divider source |
| rst | input | 1 | Synchronous active-high reset |
| req_wr | input | 1 | Register write strobe |
| req_rd | input | 1 | Register read strobe; data is valid the following cycle |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | DATA_W | Register write data |
| rd_data | output | DATA_W | Registered read data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Output enable for the data line |
| mdio_i | input | 1 | Management data in |

## Verification
The bench goes after the read turnaround, where a design that kept driving, or that sampled one MDC edge early or late, would collide with the responder or return a value shifted by one bit. It checks the divider at its extremes (0, small odd and the reset value), where an off-by-one in the half-period split yields a period of N or N+2 cycles. A second start written mid-frame must leave the opcode on the wire and the stored code alone; a design without the guard would restart or splice a second frame. Rejected codes must produce no MDC edges at all, which a design that decoded only one bit of the code would violate.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;

  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int TA_POS     = PRE_BITS + 14;
  localparam int DATA_POS   = PRE_BITS + 16;

  localparam logic [7:0] OFS_MODE  = 8'h40;
  localparam logic [7:0] OFS_TGT   = 8'h44;
  localparam logic [7:0] OFS_WDATA = 8'h48;
  localparam logic [7:0] OFS_RDATA = 8'h4C;
  localparam logic [7:0] OFS_CMD   = 8'h50;

  // frame kind decoded from the framing mode and the access code
  function automatic logic code_valid(input logic ext, input logic [1:0] code);
    return ext ? (code != 2'd3) : (code[1] == 1'b0);
  endfunction

  function automatic logic code_reads(input logic ext, input logic [1:0] code);
    return ext ? (code == 2'd2) : (code == 2'd0);
  endfunction

  function automatic logic [1:0] code_opcode(input logic ext, input logic [1:0] code);
    logic [1:0] op;
    if (ext) begin
      case (code)
        2'd0:    op = 2'b00;
        2'd1:    op = 2'b01;
        default: op = 2'b11;
      endcase
    end else begin
      op = (code == 2'd0) ? 2'b10 : 2'b01;
    end
    return op;
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic        ext,
    input logic [1:0]  code,
    input logic [4:0]  phy,
    input logic [4:0]  regad,
    input logic [15:0] payload
  );
    logic        rd;
    logic [1:0]  st;
    logic [1:0]  ta;
    logic [15:0] dat;
    rd  = code_reads(ext, code);
    st  = ext ? 2'b00 : 2'b01;
    ta  = rd ? 2'b11 : 2'b10;
    dat = rd ? 16'hFFFF : payload;
    return {{PRE_BITS{1'b1}}, st, code_opcode(ext, code), phy, regad, ta, dat};
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W:0]   period;
  logic [DIV_W-1:0] half_m1;

  assign period   = {1'b0, div_q} + 1'b1;
  assign half_m1  = period[DIV_W:1] - 1'b1;
  assign rise_evt = run && (cnt == half_m1);
  assign fall_evt = run && (cnt == div_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '1;
      cnt   <= '0;
      mdc   <= 1'b0;
    end else if (load) begin
      div_q <= (div_in == '0) ? DIV_W'(1) : div_in;
      cnt   <= '0;
      mdc   <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      if (fall_evt) begin
        cnt <= '0;
        mdc <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
        if (rise_evt) mdc <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_master_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] frame_in,
  input  logic                  rd_kind,
  input  logic                  rise_evt,
  input  logic                  fall_evt,
  input  logic                  mdio_i,
  output logic                  busy,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic                  rd_done,
  output logic [15:0]           rd_result
);

  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(DATA_POS);

  logic [FRAME_BITS-1:0] sh;
  logic [IDX_W-1:0]      bit_idx;
  logic [IDX_W-1:0]      next_idx;
  logic                  rd_q;

  assign next_idx = bit_idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '1;
      bit_idx   <= '0;
      rd_q      <= 1'b0;
      busy      <= 1'b0;
      mdio_o    <= 1'b1;
      mdio_oe   <= 1'b0;
      rd_done   <= 1'b0;
      rd_result <= '0;
    end else begin
      rd_done <= 1'b0;
      if (start && !busy) begin
        sh      <= frame_in;
        bit_idx <= '0;
        rd_q    <= rd_kind;
        busy    <= 1'b1;
        mdio_o  <= frame_in[FRAME_BITS-1];
        mdio_oe <= 1'b1;
      end else if (busy) begin
        if (rise_evt && rd_q && (bit_idx >= DATA_IDX)) begin
          rd_result <= {rd_result[14:0], mdio_i};
        end
        if (fall_evt) begin
          if (bit_idx == LAST_IDX) begin
            busy    <= 1'b0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            rd_done <= rd_q;
          end else begin
            bit_idx <= next_idx;
            sh      <= {sh[FRAME_BITS-2:0], 1'b1};
            mdio_o  <= sh[FRAME_BITS-2];
            mdio_oe <= !(rd_q && (next_idx >= TA_IDX));
          end
        end
      end
    end
  end

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_master_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_wr,
  input  logic              req_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic              busy,
  input  logic              rd_done,
  input  logic [15:0]       rd_result,
  output logic              start,
  output logic              mode_ext,
  output logic [DIV_W-1:0]  mode_div,
  output logic [4:0]        tgt_phy,
  output logic [4:0]        tgt_reg,
  output logic [15:0]       out_word,
  output logic [1:0]        cmd_code
);

  logic        mode_ctl;
  logic [15:0] in_word;
  logic        hit_mode, hit_tgt, hit_wdata, hit_cmd;
  logic        accept;
  logic        unused_hi;

  assign unused_hi = ^req_wdata[DATA_W-1:16];

  assign hit_mode  = req_wr && (req_addr == ADDR_W'(OFS_MODE));
  assign hit_tgt   = req_wr && (req_addr == ADDR_W'(OFS_TGT));
  assign hit_wdata = req_wr && (req_addr == ADDR_W'(OFS_WDATA));
  assign hit_cmd   = req_wr && (req_addr == ADDR_W'(OFS_CMD));
  assign accept    = hit_cmd && req_wdata[8] && !busy && !start &&
                     code_valid(mode_ext, req_wdata[1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_ctl <= 1'b0;
      mode_ext <= 1'b0;
      mode_div <= '1;
      tgt_phy  <= '0;
      tgt_reg  <= '0;
      out_word <= '0;
      in_word  <= '0;
      cmd_code <= '0;
      start    <= 1'b0;
    end else begin
      start <= accept;
      if (hit_mode) begin
        mode_ctl <= req_wdata[12];
        mode_ext <= req_wdata[8];
        mode_div <= req_wdata[DIV_W-1:0];
      end
      if (hit_tgt) begin
        tgt_phy <= req_wdata[12:8];
        tgt_reg <= req_wdata[4:0];
      end
      if (hit_wdata) out_word <= req_wdata[15:0];
      if (accept)    cmd_code <= req_wdata[1:0];
      if (rd_done)   in_word  <= rd_result;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (req_rd) begin
      case (req_addr)
        ADDR_W'(OFS_MODE):  rd_data <= DATA_W'({mode_ctl, 3'b000, mode_ext, mode_div});
        ADDR_W'(OFS_TGT):   rd_data <= DATA_W'({tgt_phy, 3'b000, tgt_reg});
        ADDR_W'(OFS_WDATA): rd_data <= DATA_W'(out_word);
        ADDR_W'(OFS_RDATA): rd_data <= DATA_W'(in_word);
        ADDR_W'(OFS_CMD):   rd_data <= DATA_W'({busy, 14'b0, cmd_code});
        default:            rd_data <= '0;
      endcase
    end
  end

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_master_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_wr,
  input  logic              req_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);

  localparam int DIV_W = 8;

  logic                  start;
  logic                  busy;
  logic                  mode_ext;
  logic [DIV_W-1:0]      mode_div;
  logic [4:0]            tgt_phy;
  logic [4:0]            tgt_reg;
  logic [15:0]           out_word;
  logic [1:0]            cmd_code;
  logic                  rise_evt;
  logic                  fall_evt;
  logic                  rd_done;
  logic [15:0]           rd_result;
  logic [FRAME_BITS-1:0] frame_word;
  logic                  frame_rd;

  assign frame_word = build_frame(mode_ext, cmd_code, tgt_phy, tgt_reg, out_word);
  assign frame_rd   = code_reads(mode_ext, cmd_code);

  mdio_regs #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .DIV_W (DIV_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .req_wr   (req_wr),
    .req_rd   (req_rd),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .rd_data  (rd_data),
    .busy     (busy),
    .rd_done  (rd_done),
    .rd_result(rd_result),
    .start    (start),
    .mode_ext (mode_ext),
    .mode_div (mode_div),
    .tgt_phy  (tgt_phy),
    .tgt_reg  (tgt_reg),
    .out_word (out_word),
    .cmd_code (cmd_code)
  );

  mdio_clkgen #(
    .DIV_W(DIV_W)
  ) u_clkgen (
    .clk     (clk),
    .rst     (rst),
    .run     (busy),
    .load    (start),
    .div_in  (mode_div),
    .mdc     (mdc),
    .rise_evt(rise_evt),
    .fall_evt(fall_evt)
  );

  mdio_frame u_frame (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .frame_in (frame_word),
    .rd_kind  (frame_rd),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .mdio_i   (mdio_i),
    .busy     (busy),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rd_done  (rd_done),
    .rd_result(rd_result)
  );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic [1:0] cmd_code,
  input logic [7:0] mode_div
);

  // R1
  reset_div_chk: assert property (@(posedge clk) $past(rst) |-> (mode_div == 8'hFF));

  // R3
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> !mdc);

  // R4
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (!mdc && mdio_oe));

  // R8
  oe_idle_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> !mdio_oe);

  // R9
  mdio_change_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o));

  // R10
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cmd_code));

endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .busy    (busy),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe),
  .cmd_code(cmd_code),
  .mode_div(mode_div)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_wr = 1'b0;
  logic        req_rd = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int rcnt   = 0;
  logic [63:0] cap_o;
  logic [63:0] cap_oe;
  logic [15:0] resp = '0;

  // vector: [44] ext, [43:42] code, [41:37] phy, [36:32] reg, [31:16] out data, [15:0] responder data
  localparam logic [44:0] VEC [6] = '{
    {1'b0, 2'd1, 5'h01, 5'h00, 16'h1234, 16'h0000},
    {1'b0, 2'd0, 5'h1F, 5'h1F, 16'h0000, 16'hA5C3},
    {1'b1, 2'd0, 5'h05, 5'h03, 16'hBEEF, 16'h0000},
    {1'b1, 2'd1, 5'h12, 5'h1E, 16'h0F0F, 16'h0000},
    {1'b1, 2'd2, 5'h00, 5'h07, 16'h0000, 16'h8001},
    {1'b0, 2'd0, 5'h0A, 5'h11, 16'h0000, 16'h0000}
  };

  mdio_master u_dut (
    .clk      (clk),
    .rst      (rst),
    .req_wr   (req_wr),
    .req_rd   (req_rd),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .rd_data  (rd_data),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .mdio_i   (mdio_i)
  );

  always #(CLK_P/2) clk = ~clk;

  // responder: capture on rising MDC, drive read data after falling MDC
  always @(posedge mdc) begin
    if (rcnt < 64) begin
      cap_o[63-rcnt]  = mdio_o;
      cap_oe[63-rcnt] = mdio_oe;
    end
    rcnt = rcnt + 1;
  end

  always @(negedge mdc) begin
    if (rcnt >= 48 && rcnt <= 63) mdio_i = resp[63-rcnt];
    else mdio_i = 1'b1;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 190000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 190000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_wr = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_rd = 1'b1; req_addr = a;
    @(negedge clk);
    req_rd = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 40000; i++) begin
      rd(8'h50, v);
      if (!v[16]) break;
    end
  endtask

  task automatic measure(output int p);
    time t0;
    @(posedge mdc); t0 = $time;
    @(posedge mdc); p = int'(($time - t0) / CLK_P);
  endtask

  function automatic logic tb_is_read(input logic ext, input logic [1:0] code);
    return ext ? (code == 2'd2) : (code == 2'd0);
  endfunction

  function automatic logic [63:0] tb_frame(input logic ext, input logic [1:0] code,
                                           input logic [4:0] phy, input logic [4:0] rg,
                                           input logic [15:0] d);
    logic [1:0] op;
    if (ext) op = (code == 2'd0) ? 2'b00 : (code == 2'd1) ? 2'b01 : 2'b11;
    else     op = (code == 2'd0) ? 2'b10 : 2'b01;
    return {32'hFFFF_FFFF, ext ? 2'b00 : 2'b01, op, phy, rg, 2'b10, d};
  endfunction

  task automatic verify_frame(input logic ext, input logic [1:0] code, input logic [4:0] phy,
                              input logic [4:0] rg, input logic [15:0] d, input string tag);
    logic [63:0] exp;
    logic [63:0] mask;
    exp  = tb_frame(ext, code, phy, rg, d);
    mask = tb_is_read(ext, code) ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
    check(((cap_o ^ exp) & mask) == 64'd0, {tag, " frame bits"}, cap_o & mask, exp & mask);
    check(cap_oe == mask, {tag, " R8 output enable"}, cap_oe, mask);
    check(rcnt == 64, {tag, " R4 MDC periods"}, 64'(rcnt), 64'd64);
  endtask

  initial begin
    logic [31:0] v;
    int p;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(8'h40, v); check(v == 32'h0000_00FF, "R1 mode reset", 64'(v), 64'hFF);
    rd(8'h44, v); check(v == 32'h0, "R1 target reset", 64'(v), 64'h0);
    rd(8'h50, v); check(v == 32'h0, "R1 command reset", 64'(v), 64'h0);
    rd(8'h4C, v); check(v == 32'h0, "R1 read-back reset", 64'(v), 64'h0);
    check(!mdc && !mdio_oe, "R1 idle pins", {62'b0, mdc, mdio_oe}, 64'h0);

    // R3 default divider gives period 256, R6 basic write
    wr(8'h44, 32'h0000_0302);
    wr(8'h48, 32'h0000_C0DE);
    rcnt = 0;
    wr(8'h50, 32'h0000_0101);
    measure(p);
    check(p == 256, "R3 default MDC period", 64'(p), 64'd256);
    wait_idle();
    verify_frame(1'b0, 2'd1, 5'h03, 5'h02, 16'hC0DE, "R6 default-div write");

    // R2 mode fields read back
    wr(8'h40, 32'h0000_1103);
    rd(8'h40, v); check(v == 32'h0000_1103, "R2 mode readback", 64'(v), 64'h1103);
    wr(8'h44, 32'h0000_1F15);
    rd(8'h44, v); check(v == 32'h0000_1F15, "R2 target readback", 64'(v), 64'h1F15);

    // table walk: R5 R6 R7 R8
    for (int k = 0; k < 6; k++) begin
      logic [44:0] e;
      e = VEC[k];
      wr(8'h40, {23'b0, e[44], 8'h03});
      wr(8'h44, {19'b0, e[41:37], 3'b000, e[36:32]});
      wr(8'h48, {16'b0, e[31:16]});
      resp = e[15:0];
      rcnt = 0;
      wr(8'h50, {23'b0, 1'b1, 6'b0, e[43:42]});
      rd(8'h50, v);
      check(v[16] == 1'b1, "R4 busy during frame", 64'(v[16]), 64'd1);
      wait_idle();
      verify_frame(e[44], e[43:42], e[41:37], e[36:32], e[31:16],
                   e[44] ? "R5 R7 vector" : "R5 R6 vector");
      if (tb_is_read(e[44], e[43:42])) begin
        rd(8'h4C, v);
        check(v == {16'b0, e[15:0]}, "R8 read result", 64'(v), 64'(e[15:0]));
      end
    end

    // R3 divider 5 gives period 6; divider 0 clamps to period 2
    wr(8'h40, 32'h0000_0005);
    rcnt = 0;
    wr(8'h50, 32'h0000_0101);
    measure(p);
    check(p == 6, "R3 divider 5 period", 64'(p), 64'd6);
    wait_idle();
    wr(8'h40, 32'h0000_0000);
    rcnt = 0;
    wr(8'h50, 32'h0000_0101);
    measure(p);
    check(p == 2, "R3 divider 0 period", 64'(p), 64'd2);
    wait_idle();
    check(rcnt == 64, "R4 frame length at divider 0", 64'(rcnt), 64'd64);

    // R10 start while busy is ignored
    wr(8'h40, 32'h0000_0003);
    wr(8'h44, 32'h0000_0406);
    wr(8'h48, 32'h0000_5A5A);
    rcnt = 0;
    wr(8'h50, 32'h0000_0101);
    repeat (20) @(negedge clk);
    wr(8'h50, 32'h0000_0100);
    wait_idle();
    verify_frame(1'b0, 2'd1, 5'h04, 5'h06, 16'h5A5A, "R10 second start");
    rd(8'h50, v); check(v[1:0] == 2'd1, "R10 stored code kept", 64'(v[1:0]), 64'd1);
    repeat (60) @(negedge clk);
    check(rcnt == 64, "R10 no further frame", 64'(rcnt), 64'd64);

    // R11 rejected codes
    rcnt = 0;
    wr(8'h50, 32'h0000_0102);
    repeat (3) @(negedge clk);
    rd(8'h50, v); check(v == 32'h0000_0001, "R11 basic code 2 rejected", 64'(v), 64'h1);
    wr(8'h50, 32'h0000_0103);
    repeat (3) @(negedge clk);
    rd(8'h50, v); check(v == 32'h0000_0001, "R11 basic code 3 rejected", 64'(v), 64'h1);
    wr(8'h40, 32'h0000_0103);
    wr(8'h50, 32'h0000_0103);
    repeat (40) @(negedge clk);
    rd(8'h50, v); check(v == 32'h0000_0001, "R11 extended code 3 rejected", 64'(v), 64'h1);
    check(rcnt == 0, "R11 no MDC edges", 64'(rcnt), 64'd0);

    summary();
    $finish;
  end

endmodule